// File: doc/BRIEF.md
# Sampling ADC Parallel Readout Controller

This block is the host-side sequencer for a 16-bit successive-approximation converter that presents its result on an 8-bit parallel bus. A single-cycle start request makes the controller pull chip-select and the read/convert strobe low together. The falling strobe starts a conversion in the converter. The strobe is held low for a minimum width and until the converter's busy line has fallen and then risen again. The controller then raises the strobe to enable the bus and reads the result in two byte phases steered by the byte-select line: the upper byte first, then the lower byte. Each phase waits a settle interval before it samples.

The two bytes are joined into one word. The word's coding is adapted to what the host asks for, and a one-cycle valid pulse announces it. If the converter never completes its busy handshake, a watchdog returns the sequencer to idle and flags a timeout instead. Strobe width, settle time and the watchdog budget are parameters counted in system clocks.

Top module: `adc_pbus_ctrl`

## Requirements
- R1: While reset is asserted and after its release, chip-select and strobe are high, byte-select is low, and valid and timeout are low.
- R2: A start request sampled in idle drives chip-select and strobe low at that clock edge. The strobe then stays low for at least STROBE_LOW cycles.
- R3: The strobe rises with chip-select low only after busy has been seen low and then high again. Byte-select is low when this happens.
- R4: The upper byte (result bits 15 to 8) is sampled after SETTLE cycles with byte-select low. Byte-select is then set to 1 and the lower byte (bits 7 to 0) is sampled after another SETTLE cycles. The word is upper byte followed by lower byte.
- R5: valid is a one-cycle pulse. It appears 1+2*SETTLE cycles after busy is first seen high, and chip-select is already high in that cycle.
- R6: Format inputs use 0 for straight binary and 1 for two's complement. conv_fmt_i gives the converter's coding and host_fmt_i the wanted coding. If they match, the word is passed through unchanged. If they differ, only bit 15 is inverted. Both inputs are taken when the start request is accepted.
- R7: If busy has not both fallen and risen within BUSY_TIMEOUT cycles after the strobe's minimum width ends, the controller returns to idle with chip-select and strobe high. It then pulses timeout for one cycle, exactly STROBE_LOW+BUSY_TIMEOUT cycles after chip-select fell, and gives no valid pulse.
- R8: A start request while a conversion or readout is in progress is ignored. It causes no second conversion and no second valid pulse.
- R9: The data bus is sampled only while chip-select is low and the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, accepted in idle |
| conv_fmt_i | input | 1 | Converter coding: 0 straight binary, 1 two's complement |
| host_fmt_i | input | 1 | Wanted coding: 0 straight binary, 1 two's complement |
| adc_cs_no | output | 1 | Converter chip-select, active low |
| adc_rc_o | output | 1 | Read/convert strobe: low converts, high reads |
| adc_byte_o | output | 1 | Byte-select: 0 upper byte, 1 lower byte |
| adc_busy_i | input | 1 | Converter busy, low during conversion |
| adc_data_i | input | BUS_W | Converter parallel data bus |
| word_o | output | DATA_W | Joined, format-adapted result |
| valid_o | output | 1 | One-cycle result strobe |
| timeout_o | output | 1 | One-cycle watchdog expiry strobe |

## Verification
Chip-select is due low in the same cycle the start request is first seen. valid is due 1+2*SETTLE cycles after busy is first seen high, and timeout exactly STROBE_LOW+BUSY_TIMEOUT cycles after chip-select falls. The bench numbers every falling clock edge and records at which index each of these events first shows. It drives its inputs two time units after that edge, so every comparison is between cycle indices rather than wall-clock waits. A converter model in the bench reacts to the strobe. It drives the bus only in the read state and holds each result until the next conversion ends, so a read from the wrong byte phase or the wrong moment produces a wrong word.

// File: rtl/adc_pbus_pkg.sv
package adc_pbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_STROBE = 3'd1,
      ST_WFALL  = 3'd2,
      ST_WRISE  = 3'd3,
      ST_RDHI   = 3'd4,
      ST_RDLO   = 3'd5
   } rd_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_pbus_cnt.sv
module adc_pbus_cnt #(
   parameter int unsigned W = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (dec_i) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i && !load_i) |-> (cnt_q != '0)); // R2

endmodule

// File: rtl/adc_pbus_fmt.sv
module adc_pbus_fmt #(
   parameter int unsigned DATA_W         = 16,
   parameter bit          LATCH_AT_START = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              latch_i,
   input  logic              conv_fmt_i,
   input  logic              host_fmt_i,
   input  logic [DATA_W-1:0] raw_i,
   output logic [DATA_W-1:0] word_o
);

   localparam int unsigned MSB = DATA_W - 1;

   logic conv_sel;
   logic host_sel;
   logic flip;

   if (LATCH_AT_START) begin : g_latched
      logic conv_q;
      logic host_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            conv_q <= 1'b0;
            host_q <= 1'b0;
         end else if (latch_i) begin
            conv_q <= conv_fmt_i;
            host_q <= host_fmt_i;
         end
      end
      assign conv_sel = conv_q;
      assign host_sel = host_q;
   end else begin : g_live
      assign conv_sel = conv_fmt_i;
      assign host_sel = host_fmt_i;
   end

   assign flip   = conv_sel ^ host_sel;
   assign word_o = {raw_i[MSB] ^ flip, raw_i[MSB-1:0]};

   AST_FMT_MSB_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(word_o ^ raw_i) <= 1); // R6

endmodule

// File: rtl/adc_pbus_ctrl.sv
module adc_pbus_ctrl
   import adc_pbus_pkg::*;
#(
   parameter int unsigned DATA_W         = 16,
   parameter int unsigned BUS_W          = 8,
   parameter int unsigned STROBE_LOW     = 4,
   parameter int unsigned SETTLE         = 3,
   parameter int unsigned BUSY_TIMEOUT   = 4096,
   parameter bit          LATCH_AT_START = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              conv_fmt_i,
   input  logic              host_fmt_i,
   output logic              adc_cs_no,
   output logic              adc_rc_o,
   output logic              adc_byte_o,
   input  logic              adc_busy_i,
   input  logic [BUS_W-1:0]  adc_data_i,
   output logic [DATA_W-1:0] word_o,
   output logic              valid_o,
   output logic              timeout_o
);

   localparam int unsigned PH_MAX = max2(STROBE_LOW, SETTLE);
   localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
   localparam int unsigned TO_W   = $clog2(BUSY_TIMEOUT + 1);
   localparam logic [PH_W-1:0] PH_STROBE = PH_W'(STROBE_LOW - 1);
   localparam logic [PH_W-1:0] PH_SETTLE = PH_W'(SETTLE - 1);
   localparam logic [TO_W-1:0] TO_LOAD   = TO_W'(BUSY_TIMEOUT - 1);

   if (DATA_W != 2 * BUS_W) begin : g_bad_width
      $error("adc_pbus_ctrl: DATA_W must be twice BUS_W");
   end
   if (STROBE_LOW < 2) begin : g_bad_strobe
      $error("adc_pbus_ctrl: STROBE_LOW must be at least 2");
   end
   if (SETTLE < 2) begin : g_bad_settle
      $error("adc_pbus_ctrl: SETTLE must be at least 2");
   end
   if (BUSY_TIMEOUT < 2) begin : g_bad_timeout
      $error("adc_pbus_ctrl: BUSY_TIMEOUT must be at least 2");
   end

   rd_state_e state_q, state_d;

   logic            ph_load, ph_dec, ph_zero;
   logic [PH_W-1:0] ph_val;
   logic            wd_load, wd_dec, wd_zero;
   logic            accept, cap_hi, cap_lo, expire;

   logic [BUS_W-1:0]  hi_q;
   logic [DATA_W-1:0] fmt_word;

   // phase timer: strobe width and byte settle
   adc_pbus_cnt #(.W(PH_W)) u_phase (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (ph_load),
      .load_val_i (ph_val),
      .dec_i      (ph_dec),
      .zero_o     (ph_zero)
   );

   // busy handshake watchdog
   adc_pbus_cnt #(.W(TO_W)) u_wdog (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (wd_load),
      .load_val_i (TO_LOAD),
      .dec_i      (wd_dec),
      .zero_o     (wd_zero)
   );

   adc_pbus_fmt #(
      .DATA_W         (DATA_W),
      .LATCH_AT_START (LATCH_AT_START)
   ) u_fmt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .latch_i    (accept),
      .conv_fmt_i (conv_fmt_i),
      .host_fmt_i (host_fmt_i),
      .raw_i      ({hi_q, adc_data_i}),
      .word_o     (fmt_word)
   );

   always_comb begin
      state_d = state_q;
      ph_load = 1'b0;
      ph_val  = PH_SETTLE;
      ph_dec  = 1'b0;
      wd_load = 1'b0;
      wd_dec  = 1'b0;
      accept  = 1'b0;
      cap_hi  = 1'b0;
      cap_lo  = 1'b0;
      expire  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               accept  = 1'b1;
               ph_load = 1'b1;
               ph_val  = PH_STROBE;
               state_d = ST_STROBE;
            end
         end
         ST_STROBE: begin
            if (ph_zero) begin
               wd_load = 1'b1;
               state_d = ST_WFALL;
            end else begin
               ph_dec = 1'b1;
            end
         end
         ST_WFALL: begin
            if (!adc_busy_i) begin
               wd_dec  = !wd_zero;
               state_d = ST_WRISE;
            end else if (wd_zero) begin
               expire  = 1'b1;
               state_d = ST_IDLE;
            end else begin
               wd_dec = 1'b1;
            end
         end
         ST_WRISE: begin
            if (adc_busy_i) begin
               ph_load = 1'b1;
               state_d = ST_RDHI;
            end else if (wd_zero) begin
               expire  = 1'b1;
               state_d = ST_IDLE;
            end else begin
               wd_dec = 1'b1;
            end
         end
         ST_RDHI: begin
            if (ph_zero) begin
               cap_hi  = 1'b1;
               ph_load = 1'b1;
               state_d = ST_RDLO;
            end else begin
               ph_dec = 1'b1;
            end
         end
         ST_RDLO: begin
            if (ph_zero) begin
               cap_lo  = 1'b1;
               state_d = ST_IDLE;
            end else begin
               ph_dec = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         hi_q      <= '0;
         word_o    <= '0;
         valid_o   <= 1'b0;
         timeout_o <= 1'b0;
      end else begin
         state_q   <= state_d;
         valid_o   <= cap_lo;
         timeout_o <= expire;
         if (cap_hi) hi_q   <= adc_data_i;
         if (cap_lo) word_o <= fmt_word;
      end
   end

   assign adc_cs_no  = (state_q == ST_IDLE);
   assign adc_rc_o   = !((state_q == ST_STROBE) || (state_q == ST_WFALL) ||
                         (state_q == ST_WRISE));
   assign adc_byte_o = (state_q == ST_RDLO);

   AST_CS_FALL_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(adc_cs_no) |-> $past(start_i)); // R2
   AST_RC_RISE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(adc_rc_o) && !adc_cs_no) |-> ($past(adc_busy_i) && !adc_byte_o)); // R3
   AST_BYTE_HI_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(adc_byte_o) |-> $past(!adc_byte_o && adc_rc_o && !adc_cs_no)); // R4
   AST_CAPTURE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap_hi || cap_lo) |-> (!adc_cs_no && adc_rc_o)); // R9
   AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o); // R5
   AST_TIMEOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o |=> !timeout_o); // R7
   AST_NO_VALID_AND_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(valid_o && timeout_o)); // R7
   AST_TIMEOUT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o |-> (adc_cs_no && adc_rc_o)); // R7

endmodule

// File: tb/tb_adc_pbus_ctrl.sv
module tb_adc_pbus_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int SL         = 3;
   localparam int SE         = 2;
   localparam int TO         = 40;
   localparam int CONV_LEN   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        conv_fmt = 1'b0;
   logic        host_fmt = 1'b0;
   logic        cs_n, rc, byte_sel, busy;
   wire  [7:0]  data;
   logic [15:0] word;
   logic        valid, timeout;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_pbus_ctrl #(
      .DATA_W(16), .BUS_W(8), .STROBE_LOW(SL), .SETTLE(SE), .BUSY_TIMEOUT(TO)
   ) dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .conv_fmt_i(conv_fmt), .host_fmt_i(host_fmt),
      .adc_cs_no(cs_n), .adc_rc_o(rc), .adc_byte_o(byte_sel),
      .adc_busy_i(busy), .adc_data_i(data),
      .word_o(word), .valid_o(valid), .timeout_o(timeout)
   );

   // converter model: 0 normal, 1 busy never falls, 2 busy never rises
   int          mode = 0;
   logic [15:0] next_val = 16'h0000;
   logic [15:0] res_q;
   int          m_timer;
   int          conv_cnt;
   logic        prev_conv;

   assign data = (!cs_n && rc) ? (byte_sel ? res_q[7:0] : res_q[15:8]) : 8'hzz;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b1;
         prev_conv <= 1'b1;
         m_timer   <= 0;
         res_q     <= 16'h0000;
         conv_cnt  <= 0;
      end else begin
         prev_conv <= cs_n | rc;
         if (prev_conv && !(cs_n | rc) && busy && mode != 1) begin
            busy     <= 1'b0;
            m_timer  <= CONV_LEN;
            conv_cnt <= conv_cnt + 1;
         end else if (!busy) begin
            if (m_timer > 0) m_timer <= m_timer - 1;
            else if (mode != 2) begin
               busy  <= 1'b1;
               res_q <= next_val;
            end
         end
      end
   end

   // monitor at falling edges
   int   ncyc = 0, cs_fall_at = -1, busy_rise_at = -1, valid_at = -1, to_at = -1;
   int   valid_cnt = 0, to_cnt = 0, run = 0, last_run = 0, rc_bad = 0;
   logic valid_cs = 1'b0;
   logic prev_cs = 1'b1, prev_busy = 1'b1, prev_rc = 1'b1;

   always @(negedge clk) begin
      ncyc = ncyc + 1;
      if (!cs_n && prev_cs) cs_fall_at = ncyc;
      if (busy && !prev_busy) busy_rise_at = ncyc;
      if (valid) begin
         valid_cnt = valid_cnt + 1;
         valid_at  = ncyc;
         valid_cs  = cs_n;
      end
      if (timeout) begin
         to_cnt = to_cnt + 1;
         to_at  = ncyc;
      end
      if (!rc) run = run + 1;
      else begin
         if (!prev_rc) begin
            last_run = run;
            if (!cs_n && !busy) rc_bad = rc_bad + 1;
         end
         run = 0;
      end
      prev_cs   = cs_n;
      prev_busy = busy;
      prev_rc   = rc;
   end

   task automatic tick();
      @(negedge clk);
      #2;
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic t_reset();
      check(cs_n == 1'b1,     "R1", "cs_n after reset", cs_n, 1);
      check(rc == 1'b1,       "R1", "strobe after reset", rc, 1);
      check(byte_sel == 1'b0, "R1", "byte-select after reset", byte_sel, 0);
      check(valid == 1'b0,    "R1", "valid after reset", valid, 0);
      check(timeout == 1'b0,  "R1", "timeout after reset", timeout, 0);
   endtask

   task automatic run_conv(input logic [15:0] val, input logic cf, input logic hf,
                           input bit flip_host, input bit extra_start,
                           input logic [15:0] exp_word, input string tag);
      int v0, c0, t0, s_at;
      next_val = val;
      conv_fmt = cf;
      host_fmt = hf;
      v0 = valid_cnt; c0 = conv_cnt; t0 = to_cnt;
      tick();
      start = 1'b1;
      tick();
      start = 1'b0;
      s_at = ncyc;
      if (flip_host) host_fmt = ~hf;
      if (extra_start) begin
         repeat (4) tick();
         start = 1'b1;
         tick();
         start = 1'b0;
      end
      for (int i = 0; i < 200 && valid_cnt == v0; i++) tick();
      check(valid_cnt == v0 + 1, "R5", "valid pulse count", valid_cnt - v0, 1);
      check(word == exp_word, tag, "word", word, exp_word);
      check(cs_fall_at == s_at, "R2", "cs fall cycle", cs_fall_at, s_at);
      check(last_run >= SL, "R2", "strobe low width", last_run, SL);
      check(rc_bad == 0, "R3", "strobe rise before busy high", rc_bad, 0);
      check(valid_at - busy_rise_at == 1 + 2*SE, "R5", "busy-to-valid cycles",
            valid_at - busy_rise_at, 1 + 2*SE);
      check(valid_cs == 1'b1, "R5", "cs_n with valid", valid_cs, 1);
      check(to_cnt == t0, "R7", "no timeout on good run", to_cnt - t0, 0);
      if (extra_start) begin
         repeat (30) tick();
         check(conv_cnt == c0 + 1, "R8", "conversions started", conv_cnt - c0, 1);
         check(valid_cnt == v0 + 1, "R8", "valid pulses", valid_cnt - v0, 1);
      end
   endtask

   task automatic t_timeout(input int m);
      int v0, t0, s_at;
      mode = m;
      v0 = valid_cnt; t0 = to_cnt;
      tick();
      start = 1'b1;
      tick();
      start = 1'b0;
      s_at = ncyc;
      for (int i = 0; i < 200 && to_cnt == t0; i++) tick();
      check(to_cnt == t0 + 1, "R7", "timeout pulses", to_cnt - t0, 1);
      check(to_at - s_at == SL + TO, "R7", "cs fall to timeout cycles",
            to_at - s_at, SL + TO);
      check(valid_cnt == v0, "R7", "valid on timeout", valid_cnt - v0, 0);
      check(cs_n == 1'b1 && rc == 1'b1, "R7", "idle lines after timeout",
            {cs_n, rc}, 3);
      mode = 0;
      repeat (20) tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) tick();
      t_reset();
      rst_n = 1'b1;
      repeat (2) tick();
      t_reset();
      run_conv(16'hA55A, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA55A, "R4/R9");
      run_conv(16'h8001, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0001, "R6");
      run_conv(16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 16'h8001, "R6");
      run_conv(16'h7FFF, 1'b1, 1'b1, 1'b0, 1'b0, 16'h7FFF, "R6");
      run_conv(16'h8001, 1'b0, 1'b0, 1'b1, 1'b0, 16'h8001, "R6");
      run_conv(16'h1234, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1234, "R8");
      t_timeout(1);
      t_timeout(2);
      run_conv(16'h00FF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00FF, "R7");
      run_conv(16'hFF00, 1'b1, 1'b0, 1'b0, 1'b0, 16'h7F00, "R4");
      finish_run();
   end

endmodule